// File: doc/BRIEF.md
# Serial Flash Status and Write-Protect Controller

This block holds the status byte of a serial flash device and decides, for every decoded command, whether the command may take effect. A front end that has already shifted in the opcode, the 24-bit address and an optional data byte hands the block one command event per cycle. With the event comes a flag that tells whether chip select rose on a byte boundary. The block looks at the opcode, the target address, the hardware write-protect pin and its own state. It then answers with a one-cycle accept or reject pulse. For array operations it also gives a start pulse to the array sequencer.

Program, erase and status-write commands start a self-timed busy interval. Each command kind has its own cycle count, set by a parameter. When the interval ends, the block clears the write-enable bit and raises a one-cycle done pulse. A protected region of 2, 4, 8, 16, 32 or 64 blocks of 64 KB can be placed at the top or the bottom of a 128-block array. The region can also cover the whole array. A lock bit combined with the write-protect pin can freeze the status byte. A power-down mode and a lockout window after reset block most commands.

Top module: `sflash_guard`

## Requirements
- R1: After reset, status_byte reads 00h and neither cmd_accept, cmd_reject nor op_start is high.
- R2: The status byte layout is bit0 BUSY, bit1 write-enable (WEL), bits 4..2 protect size code, bit5 bottom-select, bit6 always 0, bit7 status lock. Opcode 06h sets WEL and opcode 04h clears it.
- R3: Opcode 01h copies data bits 7, 5, 4, 3 and 2 into the status byte. Data bits 6, 1 and 0 are ignored. The stored bits change only on an accepted 01h.
- R4: Opcodes 01h, 02h (program), 20h (4 KB erase), D8h (64 KB erase) and C7h (chip erase) are rejected with no start pulse when WEL is 0. A rejected command leaves WEL unchanged.
- R5: The block index is address bits 22..16. A size code n from 1 to 6 protects 2^n blocks: the highest blocks when bottom-select is 0, the lowest blocks when it is 1. Code 0 protects nothing and code 7 protects everything. Program or erase aimed at a protected block is rejected.
- R6: Chip erase (C7h) is rejected whenever the size code is not 0.
- R7: When the lock bit is 1 and wp_n is low, opcode 01h is rejected.
- R8: Opcodes 06h, 04h, 01h, 02h, 20h, D8h and C7h are rejected when cmd_aligned is 0.
- R9: An accepted 01h, 02h, 20h, D8h or C7h holds BUSY at 1 for exactly the parameterised number of cycles for its kind. While BUSY is 1, only 05h (status read) is accepted. BUSY and WEL clear on the same edge, and op_done pulses for one cycle at that edge.
- R10: After an accepted B9h (power-down), every opcode except ABh is rejected, 05h included. An accepted ABh returns the block to normal operation.
- R11: For LOCKOUT_CYC cycles after reset, opcodes 06h, 01h, 02h, 20h, D8h and C7h are rejected. Opcodes 04h and 05h are still accepted.
- R12: Each cmd_valid gets exactly one cmd_accept or cmd_reject in the next cycle. Unknown opcodes are rejected. op_start pulses with the accept, and only for 02h, 20h, D8h and C7h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A decoded command is present this cycle |
| cmd_op | input | 8 | Command opcode |
| cmd_addr | input | ADDR_W | Target byte address |
| cmd_data | input | 8 | Data byte for the status-write command |
| cmd_aligned | input | 1 | Chip select rose after a whole number of bytes |
| wp_n | input | 1 | Hardware write-protect pin, active low |
| status_byte | output | 8 | Current status byte |
| cmd_accept | output | 1 | Command taken, one cycle after cmd_valid |
| cmd_reject | output | 1 | Command dropped, one cycle after cmd_valid |
| op_start | output | 1 | Start pulse for the array program or erase |
| op_done | output | 1 | One-cycle pulse when BUSY clears |

## Verification
The assertions assume that cmd_valid lasts one cycle per command. They also assume that every busy-length parameter is at least 1, so a timed operation can never start while the timer is still running. The bench drives each command for exactly one cycle and leaves at least one idle cycle before the next. It keeps wp_n and cmd_aligned stable while a command is in flight. It waits for BUSY to clear before it sends any command other than a status read.

// File: rtl/sfg_pkg.sv
package sfg_pkg;

    localparam logic [7:0] OPC_WREN   = 8'h06;
    localparam logic [7:0] OPC_WRDI   = 8'h04;
    localparam logic [7:0] OPC_RDSR   = 8'h05;
    localparam logic [7:0] OPC_WRSR   = 8'h01;
    localparam logic [7:0] OPC_PROG   = 8'h02;
    localparam logic [7:0] OPC_SERASE = 8'h20;
    localparam logic [7:0] OPC_BERASE = 8'hD8;
    localparam logic [7:0] OPC_CERASE = 8'hC7;
    localparam logic [7:0] OPC_SLEEP  = 8'hB9;
    localparam logic [7:0] OPC_WAKE   = 8'hAB;

    typedef enum logic [3:0] {
        ACT_NONE, ACT_WREN, ACT_WRDI, ACT_RDSR, ACT_WRSR,
        ACT_PROG, ACT_SERASE, ACT_BERASE, ACT_CERASE, ACT_SLEEP, ACT_WAKE
    } act_e;

    typedef struct packed {
        logic       lock;
        logic       zero;
        logic       bottom;
        logic [2:0] size;
        logic       wel;
        logic       busy;
    } stat_t;

    typedef struct packed {
        logic take;
        act_e act;
    } verdict_t;

    function automatic act_e decode_op(input logic [7:0] op);
        case (op)
            OPC_WREN:   return ACT_WREN;
            OPC_WRDI:   return ACT_WRDI;
            OPC_RDSR:   return ACT_RDSR;
            OPC_WRSR:   return ACT_WRSR;
            OPC_PROG:   return ACT_PROG;
            OPC_SERASE: return ACT_SERASE;
            OPC_BERASE: return ACT_BERASE;
            OPC_CERASE: return ACT_CERASE;
            OPC_SLEEP:  return ACT_SLEEP;
            OPC_WAKE:   return ACT_WAKE;
            default:    return ACT_NONE;
        endcase
    endfunction

    function automatic logic needs_boundary(input act_e a);
        return a inside {ACT_WREN, ACT_WRDI, ACT_WRSR, ACT_PROG,
                         ACT_SERASE, ACT_BERASE, ACT_CERASE};
    endfunction

    function automatic logic needs_wel(input act_e a);
        return a inside {ACT_WRSR, ACT_PROG, ACT_SERASE, ACT_BERASE, ACT_CERASE};
    endfunction

    function automatic logic is_array_op(input act_e a);
        return a inside {ACT_PROG, ACT_SERASE, ACT_BERASE, ACT_CERASE};
    endfunction

endpackage

// File: rtl/sfg_prot_map.sv
module sfg_prot_map #(
    parameter int ADDR_W = 23,
    parameter int BLK_W  = 7,
    parameter int CODE_W = 3
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [CODE_W-1:0] code,
    input  logic              from_bottom,
    output logic              hit,
    output logic              any
);
    localparam int NBLK = 1 << BLK_W;

    logic [BLK_W-1:0] blk;
    logic [BLK_W:0]   span;
    logic [BLK_W:0]   blk_x;
    logic             whole;

    assign blk   = addr[ADDR_W-1 -: BLK_W];
    assign blk_x = {1'b0, blk};

    always_comb begin
        whole = (code == {CODE_W{1'b1}}) || (int'(code) >= BLK_W);
        span  = (BLK_W+1)'(1) << code;
        if (code == '0)
            hit = 1'b0;
        else if (whole)
            hit = 1'b1;
        else if (from_bottom)
            hit = blk_x < span;
        else
            hit = blk_x >= ((BLK_W+1)'(NBLK) - span);
        any = (code != '0);
    end
endmodule

// File: rtl/sfg_busy_timer.sv
module sfg_busy_timer #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] len,
    output logic             busy,
    output logic             last,
    output logic             done
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (load) begin
                busy <= 1'b1;
                cnt  <= len - CNT_W'(1);
            end else if (busy) begin
                if (cnt == '0) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    cnt <= cnt - CNT_W'(1);
                end
            end
        end
    end

    assign last = busy && (cnt == '0);

    assert_no_reload_R9: assert property (@(posedge clk) disable iff (rst)
        load |-> !busy);
    assert_len_nonzero_R9: assert property (@(posedge clk) disable iff (rst)
        load |-> (len != '0));
    assert_done_after_busy_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(busy) && !busy));
endmodule

// File: rtl/sfg_cmd_gate.sv
module sfg_cmd_gate
    import sfg_pkg::*;
(
    input  logic [7:0] op,
    input  logic       aligned,
    input  logic       wp_n,
    input  stat_t      st,
    input  logic       asleep,
    input  logic       locked,
    input  logic       addr_hit,
    input  logic       any_prot,
    output verdict_t   v
);
    act_e a;
    logic edge_ok;
    logic unlock_ok;

    always_comb begin
        a         = decode_op(op);
        edge_ok   = !needs_boundary(a) || aligned;
        unlock_ok = !locked;
        v.act     = a;
        if (asleep)
            v.take = (a == ACT_WAKE);
        else if (st.busy)
            v.take = (a == ACT_RDSR);
        else begin
            case (a)
                ACT_RDSR, ACT_SLEEP, ACT_WAKE: v.take = 1'b1;
                ACT_WRDI:   v.take = edge_ok;
                ACT_WREN:   v.take = edge_ok && unlock_ok;
                ACT_WRSR:   v.take = edge_ok && unlock_ok && st.wel && !(st.lock && !wp_n);
                ACT_PROG, ACT_SERASE, ACT_BERASE:
                            v.take = edge_ok && unlock_ok && st.wel && !addr_hit;
                ACT_CERASE: v.take = edge_ok && unlock_ok && st.wel && !any_prot;
                default:    v.take = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/sflash_guard.sv
module sflash_guard
    import sfg_pkg::*;
#(
    parameter int ADDR_W      = 23,
    parameter int BLK_W       = 7,
    parameter int CNT_W       = 20,
    parameter int LOCKOUT_CYC = 1000,
    parameter int WSR_CYC     = 500,
    parameter int PROG_CYC    = 2000,
    parameter int SERASE_CYC  = 30000,
    parameter int BERASE_CYC  = 100000,
    parameter int CERASE_CYC  = 900000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [7:0]        cmd_data,
    input  logic              cmd_aligned,
    input  logic              wp_n,
    output logic [7:0]        status_byte,
    output logic              cmd_accept,
    output logic              cmd_reject,
    output logic              op_start,
    output logic              op_done
);
    localparam int LOCK_W = $clog2(LOCKOUT_CYC + 1);

    logic              lock_bit, bottom_bit, wel;
    logic [2:0]        size_code;
    logic              asleep;
    logic [LOCK_W-1:0] lock_cnt;
    logic              locked;
    logic              busy, tmr_last;
    logic              addr_hit, any_prot;
    logic              go;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_len;
    stat_t             st;
    verdict_t          v;

    assign locked = (lock_cnt != '0);
    assign st     = '{lock: lock_bit, zero: 1'b0, bottom: bottom_bit,
                      size: size_code, wel: wel, busy: busy};
    assign status_byte = st;

    sfg_prot_map #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .CODE_W(3)) u_map (
        .addr(cmd_addr), .code(size_code), .from_bottom(bottom_bit),
        .hit(addr_hit), .any(any_prot));

    sfg_cmd_gate u_gate (
        .op(cmd_op), .aligned(cmd_aligned), .wp_n(wp_n), .st(st),
        .asleep(asleep), .locked(locked), .addr_hit(addr_hit),
        .any_prot(any_prot), .v(v));

    assign go       = cmd_valid && v.take;
    assign tmr_load = go && (needs_wel(v.act));

    always_comb begin
        case (v.act)
            ACT_WRSR:   tmr_len = CNT_W'(WSR_CYC);
            ACT_PROG:   tmr_len = CNT_W'(PROG_CYC);
            ACT_SERASE: tmr_len = CNT_W'(SERASE_CYC);
            ACT_BERASE: tmr_len = CNT_W'(BERASE_CYC);
            ACT_CERASE: tmr_len = CNT_W'(CERASE_CYC);
            default:    tmr_len = CNT_W'(1);
        endcase
    end

    sfg_busy_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk(clk), .rst(rst), .load(tmr_load), .len(tmr_len),
        .busy(busy), .last(tmr_last), .done(op_done));

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_bit   <= 1'b0;
            bottom_bit <= 1'b0;
            size_code  <= 3'b000;
            wel        <= 1'b0;
            asleep     <= 1'b0;
            lock_cnt   <= LOCK_W'(LOCKOUT_CYC);
            cmd_accept <= 1'b0;
            cmd_reject <= 1'b0;
            op_start   <= 1'b0;
        end else begin
            cmd_accept <= go;
            cmd_reject <= cmd_valid && !v.take;
            op_start   <= go && is_array_op(v.act);
            if (locked)
                lock_cnt <= lock_cnt - LOCK_W'(1);
            if (tmr_last)
                wel <= 1'b0;
            if (go) begin
                case (v.act)
                    ACT_WREN:  wel <= 1'b1;
                    ACT_WRDI:  wel <= 1'b0;
                    ACT_WRSR: begin
                        lock_bit   <= cmd_data[7];
                        bottom_bit <= cmd_data[5];
                        size_code  <= cmd_data[4:2];
                    end
                    ACT_SLEEP: asleep <= 1'b1;
                    ACT_WAKE:  asleep <= 1'b0;
                    default: ;
                endcase
            end
        end
    end

    assert_single_reply_R12: assert property (@(posedge clk) disable iff (rst)
        !(cmd_accept && cmd_reject));
    assert_reply_follows_R12: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> (cmd_accept || cmd_reject));
    assert_start_with_accept_R12: assert property (@(posedge clk) disable iff (rst)
        op_start |-> cmd_accept);
    assert_wel_gate_R4: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !status_byte[1] && cmd_op inside {8'h01, 8'h02, 8'h20, 8'hD8, 8'hC7})
        |=> cmd_reject);
    assert_status_lock_R7: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 8'h01 && status_byte[7] && !wp_n) |=> cmd_reject);
    assert_boundary_R8: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_aligned && cmd_op inside {8'h06, 8'h04, 8'h01, 8'h02, 8'h20, 8'hD8, 8'hC7})
        |=> cmd_reject);
    assert_busy_filter_R9: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && status_byte[0] && cmd_op != 8'h05) |=> cmd_reject);
    assert_done_clears_wel_R9: assert property (@(posedge clk) disable iff (rst)
        op_done |-> (!status_byte[1] && !status_byte[0]));
    assert_sleep_filter_R10: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && asleep && cmd_op != 8'hAB) |=> cmd_reject);
    assert_lockout_R11: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && locked && cmd_op == 8'h06) |=> cmd_reject);
    assert_nv_change_R3: assert property (@(posedge clk) disable iff (rst)
        !$stable({status_byte[7], status_byte[5:2]}) |-> cmd_accept);
endmodule

// File: tb/sflash_guard_test.sv
module sflash_guard_test;
    localparam int T_LOCK = 6;
    localparam int T_WSR  = 3;
    localparam int T_PP   = 4;
    localparam int T_SE   = 5;
    localparam int T_BE   = 6;
    localparam int T_CE   = 7;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_op = '0;
    logic [22:0] cmd_addr = '0;
    logic [7:0]  cmd_data = '0;
    logic        cmd_aligned = 1'b1;
    logic        wp_n = 1'b1;
    logic [7:0]  status_byte;
    logic        cmd_accept, cmd_reject, op_start, op_done;

    int checks = 0;
    int errors = 0;
    bit ended  = 0;

    typedef struct {
        bit    acc;
        bit    start;
        string tag;
    } exp_t;
    exp_t exp_q[$];

    sflash_guard #(
        .LOCKOUT_CYC(T_LOCK), .WSR_CYC(T_WSR), .PROG_CYC(T_PP),
        .SERASE_CYC(T_SE), .BERASE_CYC(T_BE), .CERASE_CYC(T_CE)
    ) uut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_aligned(cmd_aligned),
        .wp_n(wp_n), .status_byte(status_byte), .cmd_accept(cmd_accept),
        .cmd_reject(cmd_reject), .op_start(op_start), .op_done(op_done));

    always #10 clk = ~clk;

    task automatic note(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // monitor: pops the expected reply whenever the design answers
    always @(negedge clk) begin
        if (!rst && (cmd_accept || cmd_reject)) begin
            if (exp_q.size() == 0) begin
                note(1'b0, "R12 unexpected reply", {cmd_accept, cmd_reject}, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                note(cmd_accept == e.acc && cmd_reject == !e.acc,
                     {e.tag, " accept"}, cmd_accept, e.acc);
                note(op_start == e.start, {e.tag, " start R12"}, op_start, e.start);
            end
        end
    end

    task automatic issue(input logic [7:0] op, input logic [22:0] addr,
                         input logic [7:0] data, input bit al,
                         input bit acc, input bit start, input string tag);
        exp_t e;
        e.acc = acc; e.start = start; e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
        cmd_op = op; cmd_addr = addr; cmd_data = data; cmd_aligned = al;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_aligned = 1'b1;
    endtask

    task automatic chk_st(input logic [7:0] expv, input string tag);
        note(status_byte == expv, {tag, " status"}, status_byte, expv);
    endtask

    task automatic wait_idle();
        while (status_byte[0]) @(negedge clk);
    endtask

    task automatic measure(input int expn, input string tag);
        int n = 0;
        while (status_byte[0]) begin
            n++;
            @(negedge clk);
        end
        note(n == expn, {tag, " busy length R9"}, n, expn);
        note(op_done == 1'b1, {tag, " done pulse R9"}, op_done, 1);
        note(status_byte[1] == 1'b0, {tag, " WEL cleared R9"}, status_byte[1], 0);
    endtask

    initial begin
        #(200000 * 20);
        if (!ended) begin
            ended = 1;
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk_st(8'h00, "R1");
        note(!cmd_accept && !cmd_reject && !op_start, "R1 pulses", {cmd_accept, cmd_reject, op_start}, 0);

        // R11 power-up lockout
        issue(8'h06, '0, '0, 1, 0, 0, "R11 wren locked");
        issue(8'h05, '0, '0, 1, 1, 0, "R11 rdsr");
        issue(8'h04, '0, '0, 1, 1, 0, "R11 wrdi");
        repeat (T_LOCK + 2) @(negedge clk);

        // R2 write enable / disable
        issue(8'h06, '0, '0, 1, 1, 0, "R2 wren");
        chk_st(8'h02, "R2 after wren");
        issue(8'h04, '0, '0, 1, 1, 0, "R2 wrdi");
        chk_st(8'h00, "R2 after wrdi");

        // R4 WEL gating, R12 unknown opcode
        issue(8'h01, '0, 8'h1C, 1, 0, 0, "R4 wrsr no wel");
        issue(8'h02, '0, '0, 1, 0, 0, "R4 prog no wel");
        issue(8'h99, '0, '0, 1, 0, 0, "R12 unknown op");
        chk_st(8'h00, "R4 unchanged");

        // R8 boundary, R3 masked status write
        issue(8'h06, '0, '0, 1, 1, 0, "R3 wren");
        issue(8'h01, '0, 8'hFF, 0, 0, 0, "R8 wrsr unaligned");
        chk_st(8'h02, "R8 unchanged");
        issue(8'h01, '0, 8'h47, 1, 1, 0, "R3 wrsr 47");
        chk_st(8'h07, "R3 busy+wel+size1");
        measure(T_WSR, "R3 wrsr");
        chk_st(8'h04, "R3 stored");

        // R5 top region of 2 blocks
        issue(8'h06, '0, '0, 1, 1, 0, "R5 wren");
        issue(8'h02, 23'h7E0000, '0, 1, 0, 0, "R5 prog top protected");
        chk_st(8'h06, "R4 wel kept on reject");
        issue(8'h02, 23'h7DFFFF, '0, 1, 1, 1, "R5 prog below region");
        measure(T_PP, "R9 prog");
        chk_st(8'h04, "R9 after prog");

        // R5 bottom region of 8 blocks, R9 busy filter
        issue(8'h06, '0, '0, 1, 1, 0, "R5 wren2");
        issue(8'h01, '0, 8'h2C, 1, 1, 0, "R5 wrsr 2C");
        wait_idle();
        chk_st(8'h2C, "R5 bottom size3");
        issue(8'h06, '0, '0, 1, 1, 0, "R5 wren3");
        issue(8'h20, 23'h07FFFF, '0, 1, 0, 0, "R5 serase bottom protected");
        issue(8'h20, 23'h080000, '0, 1, 1, 1, "R5 serase above region");
        chk_st(8'h2F, "R9 busy set");
        issue(8'h06, '0, '0, 1, 0, 0, "R9 wren while busy");
        issue(8'h05, '0, '0, 1, 1, 0, "R9 rdsr while busy");
        wait_idle();
        chk_st(8'h2C, "R9 after serase");

        // R6 chip erase with protection
        issue(8'h06, '0, '0, 1, 1, 0, "R6 wren");
        issue(8'hC7, '0, '0, 1, 0, 0, "R6 cerase protected");

        // R5 code 7 protects all
        issue(8'h01, '0, 8'h1C, 1, 1, 0, "R5 wrsr 1C");
        wait_idle();
        chk_st(8'h1C, "R5 all");
        issue(8'h06, '0, '0, 1, 1, 0, "R5 wren4");
        issue(8'hD8, 23'h000000, '0, 1, 0, 0, "R5 berase low all");
        issue(8'hD8, 23'h400000, '0, 1, 0, 0, "R5 berase mid all");

        // R5 upper half, 64 blocks
        issue(8'h01, '0, 8'h18, 1, 1, 0, "R5 wrsr 18");
        wait_idle();
        chk_st(8'h18, "R5 half");
        issue(8'h06, '0, '0, 1, 1, 0, "R5 wren5");
        issue(8'hD8, 23'h400000, '0, 1, 0, 0, "R5 berase upper half");
        issue(8'hD8, 23'h3F0000, '0, 1, 1, 1, "R5 berase lower half");
        measure(T_BE, "R9 berase");

        // R6 chip erase with nothing protected
        issue(8'h06, '0, '0, 1, 1, 0, "R6 wren2");
        issue(8'h01, '0, 8'h00, 1, 1, 0, "R6 wrsr 00");
        wait_idle();
        issue(8'h06, '0, '0, 1, 1, 0, "R6 wren3");
        issue(8'hC7, '0, '0, 1, 1, 1, "R6 cerase open");
        measure(T_CE, "R9 cerase");
        chk_st(8'h00, "R6 after cerase");

        // R7 status lock with wp_n
        issue(8'h06, '0, '0, 1, 1, 0, "R7 wren");
        issue(8'h01, '0, 8'h80, 1, 1, 0, "R7 set lock");
        wait_idle();
        chk_st(8'h80, "R7 lock set");
        wp_n = 1'b0;
        issue(8'h06, '0, '0, 1, 1, 0, "R7 wren2");
        issue(8'h01, '0, 8'h00, 1, 0, 0, "R7 wrsr wp low");
        chk_st(8'h82, "R7 unchanged");
        wp_n = 1'b1;
        issue(8'h01, '0, 8'h00, 1, 1, 0, "R7 wrsr wp high");
        wait_idle();
        chk_st(8'h00, "R7 cleared");

        // R8 boundary on other write commands
        issue(8'h06, '0, '0, 0, 0, 0, "R8 wren unaligned");
        chk_st(8'h00, "R8 wel stays 0");
        issue(8'h06, '0, '0, 1, 1, 0, "R8 wren");
        issue(8'h20, '0, '0, 0, 0, 0, "R8 serase unaligned");
        chk_st(8'h02, "R8 no busy");
        issue(8'h04, '0, '0, 1, 1, 0, "R8 wrdi");

        // R10 power-down
        issue(8'hB9, '0, '0, 1, 1, 0, "R10 sleep");
        issue(8'h05, '0, '0, 1, 0, 0, "R10 rdsr asleep");
        issue(8'h06, '0, '0, 1, 0, 0, "R10 wren asleep");
        issue(8'hAB, '0, '0, 1, 1, 0, "R10 wake");
        issue(8'h05, '0, '0, 1, 1, 0, "R10 rdsr awake");
        chk_st(8'h00, "R10 final");

        repeat (3) @(negedge clk);
        note(exp_q.size() == 0, "R12 replies outstanding", exp_q.size(), 0);
        if (!ended) begin
            ended = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule